// File: doc/BRIEF.md
# SDRAM Read Burst Data Pipeline

This block is a cycle-accurate model of the read data path of a single-data-rate SDRAM device. It takes decoded commands (no-operation, read, write, precharge), each with a bank, a column and an auto-precharge flag, and drives a 16-bit data bus together with an output-enable. A controller or a bus-level testbench connects to it to see exactly when read words appear, when a burst stops, and when the bus is released.

Read data comes from a fixed internal array. Each location holds a word computed from its bank and column, so the expected value of every word is known. The burst length and the CAS latency are configuration inputs and are held steady while a burst is running. A data-mask input blanks output words through a two-clock pipeline of its own. That pipeline is separate from the CAS latency delay. A write or a precharge can end a burst early. A new read replaces the rest of the burst that is running, with no gap on the bus.

Top module: `sdr_rd_pipe`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it rises, `dq_oe_o` and `pre_mark_o` are 0 and `dq_o` is all zeros.
- R2: A read registered at edge t with `cas3_i`=0 (latency 2) or `cas3_i`=1 (latency 3) puts its first word on the bus after edge t+2 or t+3 respectively, and not before. Each word equals {~col[5:0], bank[1:0], col[7:0]} for the bank and column it reads.
- R3: Words of a burst come on consecutive clocks. For a fixed length, the column runs upward and wraps inside the block of the burst length that holds the start column. `blen_i` 0, 1, 2 and 3 select 1, 2, 4 and 8 words.
- R4: When a fixed-length burst has delivered its last word and no new read has arrived, `dq_oe_o` is low from the next clock onward.
- R5: When `blen_i[2]` is 1 (full page), the burst does not end by itself. The column goes from 255 to 0 and continues.
- R6: A read registered while a burst is running supplies its first word on the clock right after the last word of the earlier burst that is still delivered. That earlier burst supplies no further words, and the bus has no idle clock between the two.
- R7: `dqm_i` high when sampled at edge t blanks the word due after edge t+2: `dq_oe_o` is low and `dq_o` is zero for that clock. The burst still advances past the blanked column.
- R8: From the edge at which a write is registered, `dq_oe_o` stays low whatever `dqm_i` does afterwards, until the data of a later read arrives. This holds provided `dqm_i` was high on the two edges before the write.
- R9: A precharge registered at edge t to the bank being read makes the last word of that burst appear after edge t+CL-1, and leaves the bus idle after edge t+CL. A precharge to a different bank has no effect on the burst.
- R10: For a read with `autopre_i` set, `pre_mark_o` pulses high, with `pre_bank_o` equal to the read's bank, in the same clock as the last word of a burst that completes. A burst that is cut short by a new read produces no pulse.
- R11: Whenever `dq_oe_o` is low, `dq_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_i | input | 2 | Command: 0 no-op, 1 read, 2 write, 3 precharge |
| bank_i | input | 2 | Bank address of the command |
| col_i | input | 8 | Start column of a read |
| autopre_i | input | 1 | Auto-precharge flag of a read |
| dqm_i | input | 1 | Output data mask, two-clock latency |
| blen_i | input | 3 | Burst length select; bit 2 set means full page |
| cas3_i | input | 1 | 0 selects CAS latency 2, 1 selects latency 3 |
| dq_o | output | 16 | Read data, zero when not driven |
| dq_oe_o | output | 1 | Data bus output enable |
| pre_mark_o | output | 1 | Auto-precharge completion pulse |
| pre_bank_o | output | 2 | Bank marked precharged by that pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a 2-bit bank, an 8-bit column, a maximum CAS latency of 3 and a mask latency of 2. The short column lets a full-page burst started at column 253 cross the page end within a few clocks, which makes the wrap visible. The latency taps of 2 and 3 are both selected from the same pipeline depth, so each scenario compares the output against the latency it set. The mask delay of 2 runs alongside either latency, so blanking and write release are exercised against both timing paths.

// File: rtl/sdr_rd_pkg.sv
// Package: shared widths, command encoding, burst slot type and the
// computed contents of the model's storage array.
// Assumes: widths below are fixed for one build; DATA_W >= BANK_W + COL_W.
package sdr_rd_pkg;

    parameter int BANK_W  = 2;
    parameter int COL_W   = 8;
    parameter int DATA_W  = 16;
    parameter int MAX_CL  = 3;
    parameter int DQM_LAT = 2;

    localparam int FILL_W = DATA_W - BANK_W - COL_W;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } sdr_cmd_e;

    // One column access travelling from the burst engine to the bus.
    typedef struct packed {
        logic              vld;
        logic              ap_end;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
    } rd_slot_t;

    // Content of the storage array at (bank, col).
    function automatic logic [DATA_W-1:0] cell_word(
        input logic [BANK_W-1:0] bank,
        input logic [COL_W-1:0]  col
    );
        return {~col[FILL_W-1:0], bank, col};
    endfunction

    // Column bits that advance inside a burst; all ones for full page.
    function automatic logic [COL_W-1:0] wrap_mask(input logic [2:0] blen);
        logic [COL_W-1:0] m;
        if (blen[2]) begin
            m = '1;
        end else begin
            case (blen[1:0])
                2'd0:    m = COL_W'(0);
                2'd1:    m = COL_W'(1);
                2'd2:    m = COL_W'(3);
                default: m = COL_W'(7);
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/sdr_burst_gen.sv
// Burst engine: holds the running burst and presents one column access
// per clock. A read reloads it, a write or a precharge to the active bank
// stops it, and a fixed-length burst stops after its last column.
// Assumes: blen_i is steady while a burst runs.
module sdr_burst_gen
    import sdr_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  sdr_cmd_e          cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic              autopre_i,
    input  logic [2:0]        blen_i,
    output rd_slot_t          slot_o
);

    logic              act_q;
    logic              ap_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  col_q;
    logic [COL_W-1:0]  cnt_q;
    logic [COL_W-1:0]  mask;
    logic              last;

    // Decode the wrap mask and detect the final column of a fixed burst.
    always_comb begin
        mask = wrap_mask(blen_i);
        last = !blen_i[2] && (cnt_q == mask);
    end

    // Present the current column access.
    always_comb begin
        slot_o.vld    = act_q;
        slot_o.ap_end = act_q && ap_q && last;
        slot_o.bank   = bank_q;
        slot_o.col    = col_q;
    end

    // Load, advance or stop the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            ap_q   <= 1'b0;
            bank_q <= '0;
            col_q  <= '0;
            cnt_q  <= '0;
        end else begin
            case (cmd_i)
                CMD_RD: begin
                    act_q  <= 1'b1;
                    ap_q   <= autopre_i;
                    bank_q <= bank_i;
                    col_q  <= col_i;
                    cnt_q  <= '0;
                end
                CMD_WR: begin
                    act_q <= 1'b0;
                end
                default: begin
                    if (cmd_i == CMD_PRE && bank_i == bank_q) begin
                        act_q <= 1'b0;
                    end else if (act_q) begin
                        if (last) begin
                            act_q <= 1'b0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                            col_q <= (col_q & ~mask) | ((col_q + 1'b1) & mask);
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/sdr_cas_delay.sv
// CAS latency delay line: a chain of slot registers with a tap chosen by
// the latency select. A write empties the chain.
// Assumes: MAX_CL is 3, so the chain has taps for latency 2 and 3;
// cas3_i is steady while data is in flight.
module sdr_cas_delay
    import sdr_rd_pkg::*;
#(
    parameter int DEPTH = MAX_CL - 1
)(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     flush_i,
    input  logic     cas3_i,
    input  rd_slot_t slot_i,
    output rd_slot_t slot_o
);

    localparam int TAP_LO = DEPTH - 2;
    localparam int TAP_HI = DEPTH - 1;

    rd_slot_t st [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        // Shift one slot per clock, cleared by reset or a write.
        always_ff @(posedge clk) begin
            if (!rst_n || flush_i) begin
                st[i] <= '0;
            end else if (i == 0) begin
                st[i] <= slot_i;
            end else begin
                st[i] <= st[(i == 0) ? 0 : i - 1];
            end
        end
    end

    // Pick the tap that matches the selected latency.
    always_comb begin
        slot_o = cas3_i ? st[TAP_HI] : st[TAP_LO];
    end

endmodule

// File: rtl/sdr_out_stage.sv
// Output stage: delays the data mask by DQM_LAT clocks, registers the bus
// word and its enable, and flags completion of an auto-precharge burst.
// Assumes: the slot arriving here is due on the bus after this edge.
module sdr_out_stage
    import sdr_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              dqm_i,
    input  rd_slot_t          slot_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o,
    output logic              pre_mark_o,
    output logic [BANK_W-1:0] pre_bank_o
);

    logic [DQM_LAT-1:0] dqm_sr;
    logic               show;

    // Mask delay line, independent of the CAS latency path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dqm_sr <= '0;
        end else begin
            dqm_sr <= {dqm_sr[DQM_LAT-2:0], dqm_i};
        end
    end

    // A word is driven when present and not masked.
    always_comb begin
        show = slot_i.vld && !dqm_sr[DQM_LAT-1];
    end

    // Register bus value, enable and precharge mark.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            dq_o       <= '0;
            dq_oe_o    <= 1'b0;
            pre_mark_o <= 1'b0;
            pre_bank_o <= '0;
        end else begin
            dq_o       <= show ? cell_word(slot_i.bank, slot_i.col) : '0;
            dq_oe_o    <= show;
            pre_mark_o <= slot_i.vld && slot_i.ap_end;
            pre_bank_o <= slot_i.bank;
        end
    end

endmodule

// File: rtl/sdr_rd_pipe.sv
// Top: read data path of a single-data-rate SDRAM model. Commands feed the
// burst engine, its accesses pass the CAS delay line, and the output stage
// applies the data mask and drives the bus.
// Assumes: commands are legal for the device; configuration is steady
// during a burst.
module sdr_rd_pipe
    import sdr_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic              autopre_i,
    input  logic              dqm_i,
    input  logic [2:0]        blen_i,
    input  logic              cas3_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o,
    output logic              pre_mark_o,
    output logic [BANK_W-1:0] pre_bank_o
);

    sdr_cmd_e cmd_e;
    logic     wr_flush;
    rd_slot_t gen_slot;
    rd_slot_t due_slot;

    // Decode the command and the write flush.
    always_comb begin
        cmd_e    = sdr_cmd_e'(cmd_i);
        wr_flush = (cmd_e == CMD_WR);
    end

    sdr_burst_gen u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd_e),
        .bank_i    (bank_i),
        .col_i     (col_i),
        .autopre_i (autopre_i),
        .blen_i    (blen_i),
        .slot_o    (gen_slot)
    );

    sdr_cas_delay u_cas (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (wr_flush),
        .cas3_i  (cas3_i),
        .slot_i  (gen_slot),
        .slot_o  (due_slot)
    );

    sdr_out_stage u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (wr_flush),
        .dqm_i      (dqm_i),
        .slot_i     (due_slot),
        .dq_o       (dq_o),
        .dq_oe_o    (dq_oe_o),
        .pre_mark_o (pre_mark_o),
        .pre_bank_o (pre_bank_o)
    );

endmodule

// File: rtl/sdr_rd_pipe_chk.sv
// Checker: timing properties of the read pipeline, observed at its ports.
// Assumes: bound to sdr_rd_pipe; reset is applied once at start.
module sdr_rd_pipe_chk
    import sdr_rd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cmd_i,
    input logic [BANK_W-1:0] bank_i,
    input logic [COL_W-1:0]  col_i,
    input logic              dqm_i,
    input logic              cas3_i,
    input logic [DATA_W-1:0] dq_o,
    input logic              dq_oe_o
);

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe_o |-> (dq_o == '0)); // R11

    AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_WR) |=> !dq_oe_o); // R8

    AST_MASK_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 3) && $past(dqm_i, 3) == 1'b1) |-> !dq_oe_o); // R7

    AST_FIRST_WORD_CL2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 3) && $past(rst_n, 2) && $past(rst_n, 1)
         && $past(cmd_i, 3) == CMD_RD && $past(dqm_i, 3) == 1'b0
         && $past(cmd_i, 2) != CMD_WR && $past(cmd_i, 1) != CMD_WR
         && !$past(cas3_i, 3) && !cas3_i)
        |-> (dq_oe_o && dq_o == cell_word($past(bank_i, 3), $past(col_i, 3)))); // R2

    AST_FIRST_WORD_CL3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 4) && $past(rst_n, 3) && $past(rst_n, 2) && $past(rst_n, 1)
         && $past(cmd_i, 4) == CMD_RD && $past(dqm_i, 4) == 1'b0
         && $past(cmd_i, 3) != CMD_WR && $past(cmd_i, 2) != CMD_WR
         && $past(cmd_i, 1) != CMD_WR
         && $past(cas3_i, 4) && cas3_i)
        |-> (dq_oe_o && dq_o == cell_word($past(bank_i, 4), $past(col_i, 4)))); // R2

endmodule

bind sdr_rd_pipe sdr_rd_pipe_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_i   (cmd_i),
    .bank_i  (bank_i),
    .col_i   (col_i),
    .dqm_i   (dqm_i),
    .cas3_i  (cas3_i),
    .dq_o    (dq_o),
    .dq_oe_o (dq_oe_o)
);

// File: tb/sim_sdr_rd_pipe.sv
// Directed bench: each scenario fills a per-cycle plan of commands and
// expected outputs, then plays it and compares after every clock edge.
module sim_sdr_rd_pipe;

    localparam int N = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd_i = 2'd0;
    logic [1:0]  bank_i = '0;
    logic [7:0]  col_i = '0;
    logic        autopre_i = 1'b0;
    logic        dqm_i = 1'b0;
    logic [2:0]  blen_i = 3'd2;
    logic        cas3_i = 1'b0;
    logic [15:0] dq_o;
    logic        dq_oe_o;
    logic        pre_mark_o;
    logic [1:0]  pre_bank_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [1:0]  p_cmd  [N];
    logic [1:0]  p_bank [N];
    logic [7:0]  p_col  [N];
    logic        p_ap   [N];
    logic        p_dqm  [N];
    logic        x_oe   [N];
    logic [15:0] x_dq   [N];
    logic        x_pm   [N];
    logic [1:0]  x_pb   [N];
    string       x_tag  [N];

    sdr_rd_pipe u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd_i),
        .bank_i     (bank_i),
        .col_i      (col_i),
        .autopre_i  (autopre_i),
        .dqm_i      (dqm_i),
        .blen_i     (blen_i),
        .cas3_i     (cas3_i),
        .dq_o       (dq_o),
        .dq_oe_o    (dq_oe_o),
        .pre_mark_o (pre_mark_o),
        .pre_bank_o (pre_bank_o)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] word_of(input logic [1:0] b, input logic [7:0] c);
        return {~c[5:0], b, c};
    endfunction

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic clear_plan(input string idle_tag);
        for (int k = 0; k < N; k++) begin
            p_cmd[k] = 2'd0; p_bank[k] = '0; p_col[k] = '0; p_ap[k] = 1'b0; p_dqm[k] = 1'b0;
            x_oe[k] = 1'b0; x_dq[k] = '0; x_pm[k] = 1'b0; x_pb[k] = '0; x_tag[k] = idle_tag;
        end
    endtask

    task automatic put_cmd(input int k, input logic [1:0] c, input logic [1:0] b, input logic [7:0] col, input logic ap);
        p_cmd[k] = c; p_bank[k] = b; p_col[k] = col; p_ap[k] = ap;
    endtask

    task automatic put_word(input int k, input logic [1:0] b, input logic [7:0] c, input string tag);
        x_oe[k] = 1'b1; x_dq[k] = word_of(b, c); x_tag[k] = tag;
    endtask

    // Play the plan: drive cycle k, clock it, compare outputs after edge k.
    task automatic run(input int n);
        for (int k = 0; k < n; k++) begin
            cmd_i = p_cmd[k]; bank_i = p_bank[k]; col_i = p_col[k];
            autopre_i = p_ap[k]; dqm_i = p_dqm[k];
            @(posedge clk);
            #2;
            check(x_tag[k], "oe", 16'(dq_oe_o), 16'(x_oe[k]));
            check(x_tag[k], "dq", dq_o, x_dq[k]);
            check(x_pm[k] ? "R10" : x_tag[k], "pre_mark", 16'(pre_mark_o), 16'(x_pm[k]));
            if (x_pm[k]) check("R10", "pre_bank", 16'(pre_bank_o), 16'(x_pb[k]));
        end
        cmd_i = 2'd0; dqm_i = 1'b0; autopre_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check("R1", "oe in reset", 16'(dq_oe_o), 16'd0);
        check("R1", "dq in reset", dq_o, 16'd0);
        check("R1", "pre_mark in reset", 16'(pre_mark_o), 16'd0);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check("R1", "oe after reset", 16'(dq_oe_o), 16'd0);
        check("R11", "dq after reset", dq_o, 16'd0);
    endtask

    // Latency 2, four words starting mid-block: 12,13,10,11.
    task automatic t_cl2_bl4();
        cas3_i = 1'b0; blen_i = 3'd2;
        clear_plan("R2/R4/R11 idle");
        put_cmd(0, 2'd1, 2'd1, 8'h12, 1'b0);
        put_word(2, 2'd1, 8'h12, "R2 first word CL2");
        put_word(3, 2'd1, 8'h13, "R3");
        put_word(4, 2'd1, 8'h10, "R3 block wrap");
        put_word(5, 2'd1, 8'h11, "R3");
        run(10);
    endtask

    // Latency 3, eight words from 35: 35,36,37,30..34.
    task automatic t_cl3_bl8();
        cas3_i = 1'b1; blen_i = 3'd3;
        clear_plan("R2/R4 idle");
        put_cmd(0, 2'd1, 2'd2, 8'h35, 1'b0);
        for (int i = 0; i < 8; i++) begin
            put_word(3 + i, 2'd2, (8'h35 & 8'hF8) | ((8'h35 + 8'(i)) & 8'h07), i == 0 ? "R2 first word CL3" : "R3");
        end
        run(15);
    endtask

    // Single word and two-word bursts at latency 2.
    task automatic t_short();
        cas3_i = 1'b0; blen_i = 3'd0;
        clear_plan("R4 idle after BL1");
        put_cmd(0, 2'd1, 2'd0, 8'h77, 1'b0);
        put_word(2, 2'd0, 8'h77, "R3 BL1");
        run(6);
        blen_i = 3'd1;
        clear_plan("R4 idle after BL2");
        put_cmd(0, 2'd1, 2'd0, 8'h77, 1'b0);
        put_word(2, 2'd0, 8'h77, "R3 BL2");
        put_word(3, 2'd0, 8'h76, "R3 BL2 wrap");
        run(7);
    endtask

    // Full page from FD crossing 255 -> 0, then stopped by a write.
    task automatic t_page_write();
        cas3_i = 1'b0; blen_i = 3'd7;
        clear_plan("R8 released");
        put_cmd(0, 2'd1, 2'd3, 8'hFD, 1'b0);
        for (int i = 0; i < 8; i++) put_word(2 + i, 2'd3, 8'hFD + 8'(i), "R5 page wrap");
        p_dqm[8] = 1'b1; p_dqm[9] = 1'b1;
        put_cmd(10, 2'd2, 2'd3, 8'h00, 1'b0);
        p_dqm[12] = 1'b1;
        run(18);
    endtask

    // Read cut short by a second read at latency 3.
    task automatic t_truncate();
        cas3_i = 1'b1; blen_i = 3'd2;
        clear_plan("R6 idle");
        put_cmd(0, 2'd1, 2'd0, 8'h40, 1'b0);
        put_cmd(2, 2'd1, 2'd2, 8'h81, 1'b0);
        put_word(3, 2'd0, 8'h40, "R6 first burst");
        put_word(4, 2'd0, 8'h41, "R6 first burst");
        put_word(5, 2'd2, 8'h81, "R6 seamless");
        put_word(6, 2'd2, 8'h82, "R6");
        put_word(7, 2'd2, 8'h83, "R6");
        put_word(8, 2'd2, 8'h80, "R6");
        run(13);
    endtask

    // Mask high at edge 3 blanks the word due after edge 5.
    task automatic t_mask();
        cas3_i = 1'b0; blen_i = 3'd3;
        clear_plan("R7 idle");
        put_cmd(0, 2'd1, 2'd1, 8'h08, 1'b0);
        for (int i = 0; i < 8; i++) put_word(2 + i, 2'd1, 8'h08 + 8'(i), "R7 unmasked");
        p_dqm[3] = 1'b1;
        x_oe[5] = 1'b0; x_dq[5] = '0; x_tag[5] = "R7 blanked";
        run(14);
    endtask

    // Precharge to another bank is ignored, to the read bank ends output.
    task automatic t_precharge();
        cas3_i = 1'b1; blen_i = 3'd7;
        clear_plan("R9 ended");
        put_cmd(0, 2'd1, 2'd1, 8'h7E, 1'b0);
        put_cmd(4, 2'd3, 2'd2, 8'h00, 1'b0);
        put_cmd(6, 2'd3, 2'd1, 8'h00, 1'b0);
        for (int i = 0; i < 6; i++) put_word(3 + i, 2'd1, 8'h7E + 8'(i), "R9 still running");
        run(15);
    endtask

    // Auto-precharge pulse on a completed burst, none on a truncated one.
    task automatic t_autopre();
        cas3_i = 1'b0; blen_i = 3'd2;
        clear_plan("R10 idle");
        put_cmd(0, 2'd1, 2'd2, 8'h20, 1'b1);
        for (int i = 0; i < 4; i++) put_word(2 + i, 2'd2, 8'h20 + 8'(i), "R10 burst");
        x_pm[5] = 1'b1; x_pb[5] = 2'd2;
        put_cmd(8, 2'd1, 2'd3, 8'h50, 1'b1);
        put_cmd(9, 2'd1, 2'd0, 8'h60, 1'b0);
        put_word(10, 2'd3, 8'h50, "R10 truncated");
        for (int i = 0; i < 4; i++) put_word(11 + i, 2'd0, 8'h60 + 8'(i), "R10 no pulse");
        run(19);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_cl2_bl4();
        t_cl3_bl8();
        t_short();
        t_page_write();
        t_truncate();
        t_mask();
        t_precharge();
        t_autopre();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule